// File: doc/BRIEF.md
# DMA Burst Transfer Size Calculator

This block works out, one bus operation at a time, how many bytes a DMA burst moves next. A start pulse loads a source address, a destination address, a byte count, a 3-bit burst-size code and two mode bits. The block then offers an operation (byte count plus the current addresses) on a valid/ready handshake. Each accepted operation advances both addresses and reduces the remaining count, until the count is used up and a one-cycle done pulse is given.

Two sizing policies are available. In the fixed-size policy every operation moves the programmed burst size. The only exceptions are an operation that would cross a 256-byte address boundary, which is cut at that boundary, and a final short remainder. In the alignment-seeking policy each operation is the largest power of two that fits. This lets misaligned addresses climb step by step up to the burst boundary. In dual-address transfers both addresses take part in the sizing decision. In single-address transfers only the source does. A dual-address fixed-size setup with misaligned addresses or a count that is not a multiple of eight is refused with a sticky error flag.

Top module: `dma_burst_sizer`

## Requirements
- R1: After a synchronous active-low reset, op_valid, done and cfg_err are all 0.
- R2: The burst size is 8 << code bytes for size_code 0 to 5. Codes 6 and 7 both give 256 bytes.
- R3: With fixed_mode = 1, op_bytes is the smallest of three limits: the burst size, the remaining count, and the bytes left before the next 256-byte boundary of op_src. In dual mode, the bytes left before the next 256-byte boundary of op_dst is a fourth limit.
- R4: With fixed_mode = 0, op_bytes is the largest power of two that satisfies all of these: it does not exceed the burst size, it does not exceed the remaining count, op_src is a multiple of it, and, in dual mode, op_dst is a multiple of it.
- R5: op_bytes is never 0 and never exceeds the remaining count. The accepted operations of one transfer add up to the starting count.
- R6: The first operation's op_src and op_dst equal the loaded addresses. Each accepted operation (op_valid and op_ready both high at a clock edge) advances both addresses by op_bytes. While op_valid is high and op_ready is low, op_bytes, op_src and op_dst hold steady.
- R7: done is high for exactly one cycle, in the cycle after the handshake that uses up the count. A start with a count of 0 gives done in the next cycle and no operation.
- R8: A start with dual_addr = 1 and fixed_mode = 1 is illegal if the source address, the destination address or the count has any of its low three bits set. Such a start sets cfg_err. cfg_err then stays set, with no op_valid and no done, until a start with a legal setup clears it.
- R9: With dual_addr = 0, the destination address has no effect on op_bytes. The check of R8 also does not apply.
- R10: A start pulse that arrives while operations are outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load a new transfer (ignored while busy) |
| start_src | input | AW | Initial source address |
| start_dst | input | AW | Initial destination address |
| start_count | input | CW | Total bytes to move |
| size_code | input | 3 | Burst-size code |
| fixed_mode | input | 1 | 1 = fixed-size policy, 0 = alignment-seeking policy |
| dual_addr | input | 1 | 1 = destination address also constrains sizing |
| op_valid | output | 1 | An operation is offered |
| op_ready | input | 1 | Consumer accepts the offered operation |
| op_bytes | output | 9 | Byte count of the offered operation |
| op_src | output | AW | Source address of the offered operation |
| op_dst | output | AW | Destination address of the offered operation |
| done | output | 1 | One-cycle pulse when the count reaches zero |
| cfg_err | output | 1 | Sticky illegal-setup flag |

## Verification
The bench aims at the corners where sizing goes wrong. It places source addresses just below a 256-byte boundary, where a fixed-size design that ignores the boundary would issue an operation that straddles it. It uses odd source and destination offsets, where an alignment design that checks only one address would emit a size that misaligns the other. It uses short tail counts, where a design that does not clip would move more bytes than asked. It also sends odd destinations in single-address mode, which a design that wrongly looks at the destination would shrink, and codes 6 and 7, which a design that does not saturate would decode as 512 or 1024 bytes. Misaligned dual fixed setups must raise the sticky error, and a start pulse sent mid-transfer must leave the running sequence untouched. Random transfers with random back-pressure then compare every operation with an independent bench model.

// File: rtl/dma_sizer_pkg.sv
// Package: shared constants, state type and size-code decode for the burst
// sizer. Assumes a doubleword of 8 bytes and a 256-byte split boundary.
package dma_sizer_pkg;

    localparam int unsigned DWORD_LOG = 3;               // 8-byte doubleword
    localparam int unsigned BOUND_LOG = 8;               // 256-byte boundary
    localparam int unsigned MAX_CODE  = 5;               // largest distinct code
    localparam int unsigned SIZE_W    = BOUND_LOG + 1;   // holds 1..256
    localparam int unsigned LOG_W     = 4;               // holds 0..BOUND_LOG

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } sizer_state_e;

    // Decode a size code into log2 of the burst size in bytes (saturating).
    function automatic logic [LOG_W-1:0] code_to_log(input logic [2:0] code);
        if (code > 3'(MAX_CODE))
            return LOG_W'(BOUND_LOG);
        return LOG_W'(code) + LOG_W'(DWORD_LOG);
    endfunction

endpackage

// File: rtl/sizer_align.sv
// Alignment-seeking size selector: picks the largest power-of-two byte count
// that is within the burst size and the remaining count, and that keeps the
// source (and, in dual mode, destination) address naturally aligned.
// Assumes rem is non-zero whenever the result is used.
module sizer_align
    import dma_sizer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic [AW-1:0]     src,
    input  logic [AW-1:0]     dst,
    input  logic [CW-1:0]     rem,
    input  logic [LOG_W-1:0]  blog,
    input  logic              dual,
    output logic [SIZE_W-1:0] bytes
);

    localparam int unsigned NCAND = BOUND_LOG + 1;

    logic [NCAND-1:0] fits;

    // One candidate per power of two from 1 to 256 bytes.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam logic [AW-1:0] LOWM = AW'((64'd1 << k) - 64'd1);
        assign fits[k] = (LOG_W'(k) <= blog)
                       && ((rem >> k) != '0)
                       && ((src & LOWM) == '0)
                       && (!dual || ((dst & LOWM) == '0));
    end

    // Pick the highest candidate that fits.
    always_comb begin
        bytes = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (fits[k])
                bytes = SIZE_W'(1) << k;
        end
    end

endmodule

// File: rtl/sizer_fixed.sv
// Fixed-size selector: uses the burst size, but stops at the next 256-byte
// boundary of the source (and destination in dual mode) and never exceeds
// the remaining count. Assumes CW is wider than SIZE_W.
module sizer_fixed
    import dma_sizer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic [AW-1:0]     src,
    input  logic [AW-1:0]     dst,
    input  logic [CW-1:0]     rem,
    input  logic [LOG_W-1:0]  blog,
    input  logic              dual,
    output logic [SIZE_W-1:0] bytes
);

    localparam logic [SIZE_W-1:0] BOUND = SIZE_W'(1) << BOUND_LOG;

    logic [SIZE_W-1:0] burst;
    logic [SIZE_W-1:0] room_src;
    logic [SIZE_W-1:0] room_dst;
    logic [SIZE_W-1:0] room;
    logic [SIZE_W-1:0] cap;
    logic              rem_small;

    // Clip the burst to the tightest boundary, then to the remaining count.
    always_comb begin
        burst     = SIZE_W'(1) << blog;
        room_src  = BOUND - SIZE_W'(src[BOUND_LOG-1:0]);
        room_dst  = BOUND - SIZE_W'(dst[BOUND_LOG-1:0]);
        room      = (dual && (room_dst < room_src)) ? room_dst : room_src;
        cap       = (burst < room) ? burst : room;
        rem_small = ((rem >> SIZE_W) == '0) && (SIZE_W'(rem) < cap);
        bytes     = rem_small ? SIZE_W'(rem) : cap;
    end

endmodule

// File: rtl/sizer_check.sv
// Setup legality check: a dual-address fixed-size transfer needs both
// addresses on doubleword boundaries and a count that is a whole number of
// doublewords. Other setups are always legal.
module sizer_check
    import dma_sizer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] count,
    input  logic          fixed,
    input  logic          dual,
    output logic          illegal
);

    logic misaligned;

    // Flag any low doubleword-offset bit in the addresses or count.
    always_comb begin
        misaligned = (src[DWORD_LOG-1:0] != '0)
                   || (dst[DWORD_LOG-1:0] != '0)
                   || (count[DWORD_LOG-1:0] != '0);
        illegal    = fixed && dual && misaligned;
    end

endmodule

// File: rtl/dma_burst_sizer.sv
// Top: loads a transfer on start, offers one sized operation at a time on a
// valid/ready handshake, advances addresses and count on each acceptance,
// pulses done when the count is used up, and holds a sticky error on an
// illegal dual fixed setup. Synchronous active-low reset.
module dma_burst_sizer
    import dma_sizer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_src,
    input  logic [AW-1:0]     start_dst,
    input  logic [CW-1:0]     start_count,
    input  logic [2:0]        size_code,
    input  logic              fixed_mode,
    input  logic              dual_addr,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [SIZE_W-1:0] op_bytes,
    output logic [AW-1:0]     op_src,
    output logic [AW-1:0]     op_dst,
    output logic              done,
    output logic              cfg_err
);

    sizer_state_e     state_q;
    logic [AW-1:0]    src_q;
    logic [AW-1:0]    dst_q;
    logic [CW-1:0]    rem_q;
    logic [LOG_W-1:0] blog_q;
    logic             fixed_q;
    logic             dual_q;
    logic             done_q;

    logic              illegal;
    logic [SIZE_W-1:0] bytes_align;
    logic [SIZE_W-1:0] bytes_fixed;
    logic              accept;
    logic              last;

    sizer_check #(.AW(AW), .CW(CW)) u_check (
        .src     (start_src),
        .dst     (start_dst),
        .count   (start_count),
        .fixed   (fixed_mode),
        .dual    (dual_addr),
        .illegal (illegal)
    );

    sizer_align #(.AW(AW), .CW(CW)) u_align (
        .src   (src_q),
        .dst   (dst_q),
        .rem   (rem_q),
        .blog  (blog_q),
        .dual  (dual_q),
        .bytes (bytes_align)
    );

    sizer_fixed #(.AW(AW), .CW(CW)) u_fixed (
        .src   (src_q),
        .dst   (dst_q),
        .rem   (rem_q),
        .blog  (blog_q),
        .dual  (dual_q),
        .bytes (bytes_fixed)
    );

    // Output selection and handshake decode.
    always_comb begin
        op_valid = (state_q == ST_RUN);
        cfg_err  = (state_q == ST_FAULT);
        op_bytes = fixed_q ? bytes_fixed : bytes_align;
        op_src   = src_q;
        op_dst   = dst_q;
        done     = done_q;
        accept   = op_valid && op_ready;
        last     = (rem_q == CW'(op_bytes));
    end

    // Transfer state: load on start, advance on acceptance, finish or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            blog_q  <= '0;
            fixed_q <= 1'b0;
            dual_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_RUN) begin
                if (accept) begin
                    src_q <= src_q + AW'(op_bytes);
                    dst_q <= dst_q + AW'(op_bytes);
                    rem_q <= rem_q - CW'(op_bytes);
                    if (last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            end else if (start) begin
                src_q   <= start_src;
                dst_q   <= start_dst;
                rem_q   <= start_count;
                blog_q  <= code_to_log(size_code);
                fixed_q <= fixed_mode;
                dual_q  <= dual_addr;
                if (illegal) begin
                    state_q <= ST_FAULT;
                end else if (start_count == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    state_q <= ST_RUN;
                end
            end
        end
    end

endmodule

// File: rtl/dma_burst_sizer_chk.sv
// Checker: temporal properties of the burst sizer, bound to the top module.
// Observes ports plus the latched mode bit and remaining count.
module dma_burst_sizer_chk
    import dma_sizer_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_valid,
    input logic              op_ready,
    input logic [SIZE_W-1:0] op_bytes,
    input logic [AW-1:0]     op_src,
    input logic [AW-1:0]     op_dst,
    input logic              done,
    input logic              cfg_err,
    input logic              fixed_q,
    input logic              dual_q,
    input logic [CW-1:0]     rem_q
);

    // R5: an offered operation is non-empty and within the remaining count.
    assert_within_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_bytes != '0) && (CW'(op_bytes) <= rem_q));

    // R6: a stalled offer holds its size and addresses.
    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_bytes)
                                 && $stable(op_src) && $stable(op_dst));

    // R7: done never lasts two cycles.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an error blocks operations and persists until a new start.
    assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !op_valid && !done);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !start |=> cfg_err);

    // R3: a fixed-size operation never crosses a 256-byte source boundary.
    assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && fixed_q |->
            ({1'b0, op_src[BOUND_LOG-1:0]} + op_bytes) <= SIZE_W'(1 << BOUND_LOG));

    // R4: an alignment-mode size is a power of two aligned on the source.
    assert_pow2_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !fixed_q |->
            ($countones(op_bytes) == 1)
            && ((op_src[SIZE_W-1:0] & (op_bytes - SIZE_W'(1))) == '0));

    // R4: in dual alignment mode the destination is aligned too.
    assert_dst_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !fixed_q && dual_q |->
            ((op_dst[SIZE_W-1:0] & (op_bytes - SIZE_W'(1))) == '0));

endmodule

bind dma_burst_sizer dma_burst_sizer_chk #(.AW(AW), .CW(CW)) u_sizer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_bytes (op_bytes),
    .op_src   (op_src),
    .op_dst   (op_dst),
    .done     (done),
    .cfg_err  (cfg_err),
    .fixed_q  (fixed_q),
    .dual_q   (dual_q),
    .rem_q    (rem_q)
);

// File: tb/test_dma_burst_sizer.sv
// Bench: directed corners plus seeded random transfers, each operation
// compared against a bench model of the sizing rules.
module test_dma_burst_sizer;

    localparam int unsigned AW       = 32;
    localparam int unsigned CW       = 24;
    localparam time         CLK_HALF = 5ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_src = '0;
    logic [AW-1:0] start_dst = '0;
    logic [CW-1:0] start_count = '0;
    logic [2:0]    size_code = '0;
    logic          fixed_mode = 1'b0;
    logic          dual_addr = 1'b0;
    logic          op_valid;
    logic          op_ready = 1'b0;
    logic [8:0]    op_bytes;
    logic [AW-1:0] op_src;
    logic [AW-1:0] op_dst;
    logic          done;
    logic          cfg_err;

    int unsigned total = 0;
    int unsigned bad = 0;

    always #(CLK_HALF) clk = ~clk;

    dma_burst_sizer #(.AW(AW), .CW(CW)) i_dma_burst_sizer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_src   (start_src),
        .start_dst   (start_dst),
        .start_count (start_count),
        .size_code   (size_code),
        .fixed_mode  (fixed_mode),
        .dual_addr   (dual_addr),
        .op_valid    (op_valid),
        .op_ready    (op_ready),
        .op_bytes    (op_bytes),
        .op_src      (op_src),
        .op_dst      (op_dst),
        .done        (done),
        .cfg_err     (cfg_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Model of the burst size for a given code (R2).
    function automatic int unsigned model_burst(input int code);
        return (code > 5) ? 256 : (8 << code);
    endfunction

    // Model of the next operation size (R3, R4, R9).
    function automatic int unsigned model_size(input int unsigned s, input int unsigned d,
                                               input int unsigned r, input int code,
                                               input bit fx, input bit du);
        int unsigned p;
        int unsigned b;
        p = model_burst(code);
        if (fx) begin
            b = 256 - (s % 256);
            if (p > b) p = b;
            if (du) begin
                b = 256 - (d % 256);
                if (p > b) p = b;
            end
            if (p > r) p = r;
        end else begin
            while (p > r || (s % p) != 0 || (du && (d % p) != 0))
                p = p / 2;
        end
        return p;
    endfunction

    // Run one legal transfer to completion, checking every operation.
    task automatic run_xfer(input string tag, input int unsigned s0, input int unsigned d0,
                            input int unsigned n, input int code, input bit fx,
                            input bit du, input bit poke);
        int unsigned s = s0;
        int unsigned d = d0;
        int unsigned rem = n;
        int unsigned e;
        int unsigned moved = 0;
        bit          r;
        bit          first = 1'b1;
        @(negedge clk);
        start_src   = AW'(s0);
        start_dst   = AW'(d0);
        start_count = CW'(n);
        size_code   = 3'(code);
        fixed_mode  = fx;
        dual_addr   = du;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 err clear after legal start", 64'(cfg_err), 64'd0);
        if (n == 0) begin
            chk("R7 zero count done", 64'(done), 64'd1);
            chk("R7 zero count no op", 64'(op_valid), 64'd0);
            @(negedge clk);
            chk("R7 done one cycle", 64'(done), 64'd0);
            return;
        end
        while (rem > 0) begin
            if (!op_valid) begin
                chk("R6 op offered while count left", 64'(op_valid), 64'd1);
                break;
            end
            e = model_size(s, d, rem, code, fx, du);
            chk(tag, 64'(op_bytes), 64'(e));
            chk("R6 src address", 64'(op_src), 64'(s));
            chk("R6 dst address", 64'(op_dst), 64'(d));
            chk("R7 no early done", 64'(done), 64'd0);
            if (poke && first) begin
                r           = 1'b0;
                start       = 1'b1;
                start_src   = AW'(32'h0000_0ff1);
                start_dst   = AW'(32'h0000_0ff3);
                start_count = CW'(3);
                size_code   = 3'd0;
                fixed_mode  = ~fx;
            end else begin
                r = ($urandom_range(0, 3) != 0);
            end
            op_ready = r;
            first    = 1'b0;
            @(negedge clk);
            start    = 1'b0;
            op_ready = 1'b0;
            if (r) begin
                s     += e;
                d     += e;
                rem   -= e;
                moved += e;
            end
        end
        chk("R5 total bytes moved", 64'(moved), 64'(n));
        chk("R7 done after last op", 64'(done), 64'd1);
        chk("R7 idle after last op", 64'(op_valid), 64'd0);
        @(negedge clk);
        chk("R7 done one cycle", 64'(done), 64'd0);
    endtask

    // Start an illegal dual fixed setup and check the error holds (R8).
    task automatic run_illegal(input int unsigned s0, input int unsigned d0, input int unsigned n);
        @(negedge clk);
        start_src   = AW'(s0);
        start_dst   = AW'(d0);
        start_count = CW'(n);
        size_code   = 3'd3;
        fixed_mode  = 1'b1;
        dual_addr   = 1'b1;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 error raised", 64'(cfg_err), 64'd1);
        for (int i = 0; i < 3; i++) begin
            op_ready = 1'b1;
            @(negedge clk);
            chk("R8 error sticky", 64'(cfg_err), 64'd1);
            chk("R8 no op while error", 64'(op_valid), 64'd0);
            chk("R8 no done while error", 64'(done), 64'd0);
        end
        op_ready = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned s;
        int unsigned d;
        int unsigned n;
        int          code;
        bit          fx;
        bit          du;
        void'($urandom(32'd4937));
        repeat (2) @(negedge clk);
        chk("R1 op_valid in reset", 64'(op_valid), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 cfg_err in reset", 64'(cfg_err), 64'd0);
        rst_n = 1'b1;

        // R2: saturating codes and the largest distinct code.
        run_xfer("R2 code 7 size", 32'h1000, 32'h2000, 512, 7, 1'b1, 1'b0, 1'b0);
        run_xfer("R2 code 6 size", 32'h1000, 32'h2000, 512, 6, 1'b0, 1'b0, 1'b0);
        run_xfer("R2 code 5 size", 32'h1100, 32'h2100, 256, 5, 1'b1, 1'b1, 1'b0);
        // R3: fixed bursts split at a 256-byte boundary.
        run_xfer("R3 split at boundary", 32'h10f8, 32'h0, 200, 2, 1'b1, 1'b0, 1'b0);
        run_xfer("R3 dual dst boundary", 32'h1000, 32'h20e0, 256, 5, 1'b1, 1'b1, 1'b0);
        // R4: alignment climb from odd addresses, dual constrains both.
        run_xfer("R4 align climb", 32'h1003, 32'h0, 300, 4, 1'b0, 1'b0, 1'b0);
        run_xfer("R4 dual align", 32'h1010, 32'h2001, 100, 3, 1'b0, 1'b1, 1'b0);
        // R5: short tail clipped to the remaining count.
        run_xfer("R5 short tail", 32'h1000, 32'h0, 13, 5, 1'b1, 1'b0, 1'b0);
        // R7: zero count.
        run_xfer("R7 zero count", 32'h1000, 32'h0, 0, 2, 1'b0, 1'b0, 1'b0);
        // R9: single-address mode ignores an odd destination.
        run_xfer("R9 single ignores dst align", 32'h1000, 32'h2003, 64, 3, 1'b0, 1'b0, 1'b0);
        run_xfer("R9 single fixed odd dst", 32'h1013, 32'h20f9, 100, 2, 1'b1, 1'b0, 1'b0);
        // R10: start pulse mid-transfer is ignored.
        run_xfer("R10 busy start ignored", 32'h1000, 32'h3000, 96, 1, 1'b1, 1'b1, 1'b1);
        // R8: each illegal condition, then recovery by a legal start.
        run_illegal(32'h1004, 32'h2000, 64);
        run_xfer("R8 recover", 32'h1000, 32'h2000, 64, 2, 1'b1, 1'b1, 1'b0);
        run_illegal(32'h1000, 32'h2002, 64);
        run_illegal(32'h1000, 32'h2000, 20);
        run_xfer("R8 recover again", 32'h1000, 32'h2000, 40, 0, 1'b1, 1'b1, 1'b0);

        // Random transfers.
        for (int t = 0; t < 60; t++) begin
            s    = 32'h0001_0000 + $urandom_range(0, 4095);
            d    = 32'h0008_0000 + $urandom_range(0, 4095);
            n    = $urandom_range(1, 1200);
            code = int'($urandom_range(0, 7));
            fx   = 1'($urandom_range(0, 1));
            du   = 1'($urandom_range(0, 1));
            if (fx && du) begin
                s = s & ~32'd7;
                d = d & ~32'd7;
                n = (n + 7) & ~32'd7;
            end
            run_xfer(fx ? "R3 random fixed" : "R4 random align", s, d, n, code, fx, du,
                     ($urandom_range(0, 7) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule